// File: doc/BRIEF.md
# Linked-Table Trace Address Translator

This block sits between a writer that streams trace data into a linear address window and the system memory that actually holds the buffer as scattered 4 KB pages. Software builds a chain of page tables in memory. Each table is one 4 KB page. Its low 2 KB holds up to 256 eight-byte page pointers, so one table covers 1 MB of the input window. Its last two slots link to the neighbouring tables in the chain. The block takes one address request at a time and works out the table number and the slot within that table. It reads table words through a 64-bit memory read port and returns either the translated physical address or an error.

A table word carries a 4 KB-aligned physical address in its upper bits and a valid flag in bit 0. The block remembers the base and number of the table it visited last. To reach a different table it steps along the chain one link at a time, using the next link to move up and the previous link to move down. A small write-only configuration port sets the enable bit, the mode, the table base and the input base. A status output shows when the unit is idle.

Top module: `ltab_xlat`

## Requirements
- R1: While the enable bit is clear, `req_ready` stays low, no response is produced and no memory read is issued.
- R2: `ready` is high whenever the unit is idle. It is low from the cycle after a request is accepted until its response has been taken.
- R3: In pass-through mode the response carries the request address unchanged with `rsp_err` low, and no memory read is made.
- R4: In translate mode, offset = address − input base. The table number is offset bits AW-1:20 and the slot is offset bits 19:12. The table word is read at table base + slot×8. The result is word bits AW-1:12 joined with request bits 11:0.
- R5: A page-pointer word with bit 0 clear gives `rsp_err` high.
- R6: The next link is read at byte 0xFF8 of a table (slot 511) and the previous link at byte 0xFF0 (slot 510). Each step is one read and moves the remembered table number by one. The remembered table persists between requests, so a request in the same table costs exactly one read.
- R7: A link word with bit 0 clear ends the walk with `rsp_err` high. The remembered table stays at the last valid table reached.
- R8: A translate request below the input base returns `rsp_err` high with no memory read.
- R9: Bits 19:0 of a written input base and bits 11:0 of a written table base are ignored.
- R10: While disabled, the remembered table is reloaded from the table base as table number 0.
- R11: A response is held, with its address and error flag unchanged, until `rsp_ready` is high. The address reads 0 on an error.
- R12: A memory read request is held, with its address unchanged, until `mem_req_ready` is high.
- R13: Configuration writes use `cfg_sel` as follows: 0 is control (bit 0 is enable), 1 is mode (bit 0 = 1 means translate, 0 means pass-through), 2 is table base and 3 is input base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | AW | Configuration write data |
| ready | output | 1 | Unit idle |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted |
| req_addr | input | AW | Input-window address |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_addr | output | AW | Translated address |
| rsp_err | output | 1 | Translation failed |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Table read accepted |
| mem_req_addr | output | AW | Table word byte address |
| mem_rsp_valid | input | 1 | Table word returned |
| mem_rsp_data | input | 64 | Table word |

## Verification
The bench builds a three-table chain in which the input base and table base are written with junk in their ignored low bits. It sends addresses that land on the first and last slot of a table and that jump up two tables and back down. Other addresses fall on a zeroed slot in the last table, beyond the final link, or below the base. The number of memory reads is counted for every request. A design that ignored the cache, stepped the wrong way or did not restore the cache after a failed link would show the wrong read count. A design that wrongly masked the bases or mis-placed the link slots would return wrong addresses. Stalls on both the memory port and the response port check that requests are held stable. A disable and re-enable must restart from the first table, and pass-through must bypass memory entirely.

// File: rtl/ltab_pkg.sv
// Shared constants and types for the linked-table translator.
// Assumes 4 KB pages and 1 MB table reach.
package ltab_pkg;
    localparam int PG_SHIFT  = 12;
    localparam int TBL_SHIFT = 20;
    localparam logic [8:0] SLOT_PREV = 9'd510;
    localparam logic [8:0] SLOT_NEXT = 9'd511;

    localparam logic [1:0] SEL_CTRL  = 2'd0;
    localparam logic [1:0] SEL_MODE  = 2'd1;
    localparam logic [1:0] SEL_TBASE = 2'd2;
    localparam logic [1:0] SEL_IBASE = 2'd3;

    typedef enum logic [2:0] {
        ST_IDLE, ST_DECIDE, ST_MREQ, ST_MWAIT, ST_RESP
    } walk_state_t;

    typedef enum logic [1:0] {
        FK_ENTRY, FK_NEXT, FK_PREV
    } fetch_kind_t;
endpackage

// File: rtl/ltab_cfg.sv
// Configuration registers: enable, mode, table base and input base.
// Assumes AW > 20. Low bits of the bases are dropped, not stored.
module ltab_cfg
    import ltab_pkg::*;
#(
    parameter int AW = 48
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [1:0]              cfg_sel,
    input  logic [AW-1:0]           cfg_wdata,
    output logic                    en,
    output logic                    xl,
    output logic [AW-PG_SHIFT-1:0]  tbase_pg,
    output logic [AW-TBL_SHIFT-1:0] ibase_mb
);
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^cfg_wdata[PG_SHIFT-1:1];

    // Register writes selected by cfg_sel
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en       <= 1'b0;
            xl       <= 1'b0;
            tbase_pg <= '0;
            ibase_mb <= '0;
        end else if (cfg_we) begin
            case (cfg_sel)
                SEL_CTRL:  en       <= cfg_wdata[0];
                SEL_MODE:  xl       <= cfg_wdata[0];
                SEL_TBASE: tbase_pg <= cfg_wdata[AW-1:PG_SHIFT];
                default:   ibase_mb <= cfg_wdata[AW-1:TBL_SHIFT];
            endcase
        end
    end
endmodule

// File: rtl/ltab_walk.sv
// Request engine. It accepts one address at a time and resolves it by
// pass-through or by walking the linked table chain one link per read.
// It remembers the last table reached. Assumes 20 < AW < 64 and a memory
// port that returns one word per accepted read.
module ltab_walk
    import ltab_pkg::*;
#(
    parameter int AW = 48
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic                    xl,
    input  logic [AW-PG_SHIFT-1:0]  tbase_pg,
    input  logic [AW-TBL_SHIFT-1:0] ibase_mb,
    output logic                    ready,
    input  logic                    req_valid,
    output logic                    req_ready,
    input  logic [AW-1:0]           req_addr,
    output logic                    rsp_valid,
    input  logic                    rsp_ready,
    output logic [AW-1:0]           rsp_addr,
    output logic                    rsp_err,
    output logic                    mem_req_valid,
    input  logic                    mem_req_ready,
    output logic [AW-1:0]           mem_req_addr,
    input  logic                    mem_rsp_valid,
    input  logic [63:0]             mem_rsp_data
);
    localparam int PGW = AW - PG_SHIFT;
    localparam int TNW = AW - TBL_SHIFT;

    walk_state_t state;
    fetch_kind_t kind;
    logic [AW-1:0]  addr_q;
    logic [PGW-1:0] cur_pg;
    logic [TNW-1:0] cur_num;
    logic [8:0]     slot_q;

    logic [AW-1:0]  ibase_full;
    logic [AW-1:0]  off;
    logic [TNW-1:0] want_num;
    logic [7:0]     want_idx;
    logic           below;
    logic           word_ok;
    logic [PGW-1:0] word_pg;
    logic           unused_bits;

    // Offset, table number and slot of the held request
    always_comb begin
        ibase_full = {ibase_mb, {TBL_SHIFT{1'b0}}};
        off        = addr_q - ibase_full;
        want_num   = off[AW-1:TBL_SHIFT];
        want_idx   = off[TBL_SHIFT-1:PG_SHIFT];
        below      = addr_q < ibase_full;
        word_ok    = mem_rsp_data[0];
        word_pg    = mem_rsp_data[AW-1:PG_SHIFT];
    end

    assign unused_bits = ^{off[PG_SHIFT-1:0], mem_rsp_data[63:AW], mem_rsp_data[PG_SHIFT-1:1]};

    assign ready         = (state == ST_IDLE);
    assign req_ready     = en && (state == ST_IDLE);
    assign rsp_valid     = (state == ST_RESP);
    assign mem_req_valid = (state == ST_MREQ);
    assign mem_req_addr  = {cur_pg, slot_q, 3'b000};

    // Walk sequencing, table cache and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            kind     <= FK_ENTRY;
            addr_q   <= '0;
            cur_pg   <= '0;
            cur_num  <= '0;
            slot_q   <= '0;
            rsp_addr <= '0;
            rsp_err  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (!en) begin
                        cur_pg  <= tbase_pg;
                        cur_num <= '0;
                    end else if (req_valid) begin
                        addr_q <= req_addr;
                        state  <= ST_DECIDE;
                    end
                end
                ST_DECIDE: begin
                    if (!xl) begin
                        rsp_addr <= addr_q;
                        rsp_err  <= 1'b0;
                        state    <= ST_RESP;
                    end else if (below) begin
                        rsp_addr <= '0;
                        rsp_err  <= 1'b1;
                        state    <= ST_RESP;
                    end else if (want_num == cur_num) begin
                        slot_q <= {1'b0, want_idx};
                        kind   <= FK_ENTRY;
                        state  <= ST_MREQ;
                    end else if (want_num > cur_num) begin
                        slot_q <= SLOT_NEXT;
                        kind   <= FK_NEXT;
                        state  <= ST_MREQ;
                    end else begin
                        slot_q <= SLOT_PREV;
                        kind   <= FK_PREV;
                        state  <= ST_MREQ;
                    end
                end
                ST_MREQ: begin
                    if (mem_req_ready) state <= ST_MWAIT;
                end
                ST_MWAIT: begin
                    if (mem_rsp_valid) begin
                        if (!word_ok) begin
                            rsp_addr <= '0;
                            rsp_err  <= 1'b1;
                            state    <= ST_RESP;
                        end else if (kind == FK_ENTRY) begin
                            rsp_addr <= {word_pg, addr_q[PG_SHIFT-1:0]};
                            rsp_err  <= 1'b0;
                            state    <= ST_RESP;
                        end else begin
                            cur_pg  <= word_pg;
                            cur_num <= (kind == FK_NEXT) ? cur_num + 1'b1 : cur_num - 1'b1;
                            state   <= ST_DECIDE;
                        end
                    end
                end
                default: begin
                    if (rsp_ready) state <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/ltab_xlat.sv
// Top level of the linked-table translator: configuration registers plus
// the walk engine. Assumes 20 < AW < 64.
module ltab_xlat
    import ltab_pkg::*;
#(
    parameter int AW = 48
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    output logic          ready,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic [AW-1:0] req_addr,
    output logic          rsp_valid,
    input  logic          rsp_ready,
    output logic [AW-1:0] rsp_addr,
    output logic          rsp_err,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [63:0]   mem_rsp_data
);
    logic                    cfg_en;
    logic                    cfg_xl;
    logic [AW-PG_SHIFT-1:0]  cfg_tbase_pg;
    logic [AW-TBL_SHIFT-1:0] cfg_ibase_mb;

    ltab_cfg #(.AW(AW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .en(cfg_en), .xl(cfg_xl),
        .tbase_pg(cfg_tbase_pg), .ibase_mb(cfg_ibase_mb)
    );

    ltab_walk #(.AW(AW)) u_walk (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .xl(cfg_xl),
        .tbase_pg(cfg_tbase_pg), .ibase_mb(cfg_ibase_mb), .ready(ready),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr),
        .rsp_err(rsp_err), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );
endmodule

// File: rtl/ltab_xlat_chk.sv
// Protocol and behaviour checks for ltab_xlat, attached by bind.
module ltab_xlat_chk #(
    parameter int AW = 48
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          xl,
    input logic [AW-21:0] ibase_mb,
    input logic          ready,
    input logic          req_valid,
    input logic          req_ready,
    input logic [AW-1:0] req_addr,
    input logic          rsp_valid,
    input logic          rsp_ready,
    input logic [AW-1:0] rsp_addr,
    input logic          rsp_err,
    input logic          mem_req_valid,
    input logic          mem_req_ready,
    input logic [AW-1:0] mem_req_addr
);
    a_r1_no_accept_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !req_ready);

    a_r2_busy_while_fetching: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !ready);

    a_r3_pass_unchanged: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !xl) |=> ##1
        (rsp_valid && !rsp_err && rsp_addr == $past(req_addr, 2)));

    a_r8_below_base_no_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && xl && (req_addr < {ibase_mb, 20'b0})) |=>
        !mem_req_valid ##1 (rsp_valid && rsp_err && !mem_req_valid));

    a_r6_slot_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> (mem_req_addr[2:0] == 3'b000) &&
        (!mem_req_addr[11] || mem_req_addr[11:3] >= 9'd510));

    a_r11_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_addr) && $stable(rsp_err)));

    a_r12_mreq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
endmodule

bind ltab_xlat ltab_xlat_chk #(.AW(AW)) i_chk (
    .clk(clk), .rst_n(rst_n), .en(cfg_en), .xl(cfg_xl), .ibase_mb(cfg_ibase_mb),
    .ready(ready), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_err(rsp_err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr)
);

// File: tb/test_ltab_xlat.sv
`timescale 1ns/1ps
module test_ltab_xlat;
    localparam int AW = 48;
    localparam logic [47:0] IBASE = 48'h0100_0000;
    localparam int NVEC = 10;
    localparam logic [47:0] VEC [NVEC] = '{
        48'h0100_0000, 48'h0100_0ABC, 48'h010F_FFFF, 48'h0110_0123, 48'h0120_9FFC,
        48'h0120_A000, 48'h0130_0000, 48'h00FF_FFFF, 48'h0104_5678, 48'h011F_F001
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [1:0] cfg_sel = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic ready, req_ready, rsp_valid, rsp_err, mem_req_valid;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic rsp_ready = 1'b1;
    logic [AW-1:0] rsp_addr, mem_req_addr;
    logic mem_req_ready = 1'b1;
    logic mem_rsp_valid = 1'b0;
    logic [63:0] mem_rsp_data = '0;

    int checks = 0;
    int fails = 0;
    int fetches = 0;
    int bcur = 0;
    logic xl_mode = 1'b0;
    logic pend = 1'b0;
    logic [47:0] pend_addr = '0;

    always #2 clk = ~clk;

    ltab_xlat #(.AW(AW)) i_ltab_xlat (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .ready(ready), .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_err(rsp_err),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
    );

    // Memory image: tables 0,1,2 at 0x7000, 0x3000, 0xB000; table 2 has 10 valid slots
    function automatic logic [63:0] mem_word(input logic [47:0] a);
        int k;
        int s;
        s = int'(a[11:3]);
        case (a[47:12])
            36'h7:   k = 0;
            36'h3:   k = 1;
            36'hB:   k = 2;
            default: k = 3;
        endcase
        if (k == 3) return 64'd0;
        if (s < 256) begin
            if (k == 2 && s >= 10) return 64'd0;
            return ((64'h80000 + 64'(k * 256 + s)) << 12) | 64'h1;
        end
        if (s == 510) return (k == 0) ? 64'd0 : (k == 1) ? 64'h7001 : 64'h3001;
        if (s == 511) return (k == 0) ? 64'h3001 : (k == 1) ? 64'hB001 : 64'd0;
        return 64'd0;
    endfunction

    // Memory port model: one word returned one cycle after acceptance
    always @(negedge clk) begin
        mem_rsp_valid <= 1'b0;
        if (pend) begin
            mem_rsp_valid <= 1'b1;
            mem_rsp_data  <= mem_word(pend_addr);
            pend <= 1'b0;
        end
        if (mem_req_valid && mem_req_ready) begin
            pend <= 1'b1;
            pend_addr <= mem_req_addr;
            fetches <= fetches + 1;
        end
    end

    task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [1:0] sel, input logic [47:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Expected result from the requirements; updates the bench's table tracker
    task automatic predict(input logic [47:0] a, output logic e_err, output logic [47:0] e_addr, output int e_n);
        logic [47:0] off;
        int t;
        int i;
        e_n = 0; e_err = 1'b0; e_addr = a;
        if (!xl_mode) return;
        if (a < IBASE) begin e_err = 1'b1; e_addr = '0; return; end
        off = a - IBASE;
        t = int'(off >> 20);
        i = int'(off[19:12]);
        while (bcur != t) begin
            e_n++;
            if (t > bcur) begin
                if (bcur >= 2) begin e_err = 1'b1; e_addr = '0; return; end
                bcur++;
            end else bcur--;
        end
        e_n++;
        if (t == 2 && i >= 10) begin e_err = 1'b1; e_addr = '0; return; end
        e_addr = 48'(((64'h80000 + 64'(t * 256 + i)) << 12) | 64'(a[11:0]));
    endtask

    task automatic xlate(input logic [47:0] a, input string tag, input bit stall_mem, input bit hold_rsp);
        logic e_err;
        logic [47:0] e_addr;
        int e_n;
        int f0;
        bit acc;
        logic [47:0] held_addr;
        logic held_err;
        predict(a, e_err, e_addr, e_n);
        @(negedge clk);
        if (stall_mem) mem_req_ready = 1'b0;
        if (hold_rsp) rsp_ready = 1'b0;
        f0 = fetches;
        req_valid = 1'b1; req_addr = a;
        do begin
            acc = req_ready;
            @(negedge clk);
        end while (!acc);
        req_valid = 1'b0;
        check(ready == 1'b0, {tag, " R2 busy after accept"}, 64'(ready), 64'd0);
        if (stall_mem) begin
            repeat (2) @(negedge clk);
            held_addr = mem_req_addr;
            repeat (3) @(negedge clk);
            check(mem_req_valid && mem_req_addr == held_addr && mem_req_addr == 48'h7010,
                  {tag, " R12 R6 read held"}, 64'(mem_req_addr), 64'h7010);
            mem_req_ready = 1'b1;
        end
        while (!rsp_valid) @(negedge clk);
        if (hold_rsp) begin
            held_addr = rsp_addr; held_err = rsp_err;
            repeat (3) @(negedge clk);
            check(rsp_valid && rsp_addr == held_addr && rsp_err == held_err,
                  {tag, " R11 response held"}, 64'(rsp_addr), 64'(held_addr));
            rsp_ready = 1'b1;
        end
        check(rsp_err == e_err, {tag, " error flag"}, 64'(rsp_err), 64'(e_err));
        check(rsp_addr == e_addr, {tag, " address"}, 64'(rsp_addr), 64'(e_addr));
        check(fetches - f0 == e_n, {tag, " read count"}, 64'(fetches - f0), 64'(e_n));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int f0;
        bit quiet;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(ready && !req_ready && !rsp_valid && !mem_req_valid, "reset state R2 R1",
              64'({ready, req_ready, rsp_valid, mem_req_valid}), 64'b1000);

        // R9 R13: junk in ignored low bits of both bases
        cfg_write(2'd3, 48'h010A_BCDE);
        cfg_write(2'd2, 48'h0000_7ABC);
        cfg_write(2'd1, 48'h1);
        xl_mode = 1'b1;

        // R1: request while disabled
        f0 = fetches;
        quiet = 1'b1;
        req_valid = 1'b1; req_addr = 48'h0100_0000;
        repeat (6) begin
            @(negedge clk);
            if (req_ready || rsp_valid) quiet = 1'b0;
        end
        req_valid = 1'b0;
        check(quiet && fetches == f0, "R1 disabled ignores request", 64'(quiet), 64'd1);

        cfg_write(2'd0, 48'h1);
        bcur = 0;
        // Vector table: R4 R5 R6 R7 R8 R9
        for (int v = 0; v < NVEC; v++) xlate(VEC[v], "R4/R5/R6/R7/R8/R9 vector", 1'b0, 1'b0);

        // R10: disable then re-enable restarts from table 0
        cfg_write(2'd0, 48'h0);
        @(negedge clk);
        bcur = 0;
        cfg_write(2'd0, 48'h1);
        xlate(48'h0100_0010, "R10 reload", 1'b0, 1'b0);

        // R12: stalled read on slot 2 of table 0
        xlate(48'h0100_2044, "R12 stall", 1'b1, 1'b0);
        // R11: response backpressure, success and error cases
        xlate(48'h0110_5000, "R11 hold", 1'b0, 1'b1);
        xlate(48'h00F0_0000, "R11 hold err", 1'b0, 1'b1);

        // R3 R13: pass-through mode
        cfg_write(2'd0, 48'h0);
        cfg_write(2'd1, 48'h0);
        xl_mode = 1'b0;
        cfg_write(2'd0, 48'h1);
        xlate(48'h1234_5678_9ABC, "R3/R13 pass-through", 1'b0, 1'b0);
        xlate(48'h0000_0000_0001, "R3 pass-through low", 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule